// File: doc/BRIEF.md
# Subcarrier Load Modulation Encoder

This block is the transmit side of a proximity transponder that answers a reader by switching a load across its antenna. It runs directly on the carrier clock. One divider chain, cleared by a single synchronous reset, produces all of its timing. That chain gives two square-wave subcarriers, carrier/32 and carrier/28, and a bit counter that marks bit edges at carrier/512 (fast rate) or carrier/2048 (slow rate).

Serial data arrives one bit at a time over a valid/ready handshake. Each accepted bit is Manchester encoded over the following bit period. The Manchester level then picks the subcarrier that drives the single load-switch output. In frequency-shift mode the two subcarriers alternate. In amplitude-shift mode the carrier/28 subcarrier is gated off, so one level sends no subcarrier at all. When no bit is pending, the switch stays open.

The modulation mode is sampled at every bit edge. The rate select is sampled only at carrier/2048 edges, where fast and slow bit edges coincide. This keeps every bit whole.

Top module: `lmod_encoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the subcarrier dividers, the bit counter and the transmit state. After reset `load_sw` and `in_ready` are 0, and the first bit edge (`in_ready` high) comes in the 512th cycle after reset is released (count 511).
- R2: Counted in carrier cycles from reset, the high subcarrier is high for counts 0..15 of each 32-cycle period, and the low subcarrier is high for counts 0..13 of each 28-cycle period.
- R3: `in_ready` is high for exactly one cycle per bit period. At the fast rate this is count 511 of every 512 cycles. At the slow rate it is count 2047 of every 2048 cycles.
- R4: A bit is taken only when `in_valid` and `in_ready` are both high, and it is sent during the whole bit period that follows.
- R5: Manchester coding: bit 1 gives a high level in the first half of its period and a low level in the second half. Bit 0 gives the reverse.
- R6: With `fsk_mode`=1, a high level puts the carrier/32 subcarrier on `load_sw` and a low level puts the carrier/28 subcarrier on it.
- R7: With `fsk_mode`=0, a high level puts the carrier/32 subcarrier on `load_sw` and a low level holds `load_sw` at 0.
- R8: If no bit is taken at a bit edge, `load_sw` is 0 for the whole next bit period.
- R9: `fsk_mode` is sampled at each bit edge and stays fixed for that bit.
- R10: `slow_rate` (1 = carrier/2048 bit period) is sampled only at count 2047 of the 2048-cycle frame. A change at any other time has no effect until that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst | input | 1 | Synchronous reset, active high |
| fsk_mode | input | 1 | 1 = two-tone frequency shift, 0 = on/off amplitude shift |
| slow_rate | input | 1 | 1 = carrier/2048 bit period, 0 = carrier/512 |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | Offered data bit |
| in_ready | output | 1 | Bit edge: the offered bit is taken at this clock edge |
| load_sw | output | 1 | Load modulation switch control |

## Verification
A divider that slips shows up within one subcarrier period, because `load_sw` is compared against a cycle-exact model on every cycle while a bit is active. A bit counter that is off by one moves `in_ready` away from its expected count at the next bit edge, at most 2048 cycles later. A wrong latched mode, rate or data bit corrupts the next half-bit of the output waveform. The bench checks this over back-to-back bits that mix both modes and both rates, and also checks that an idle period and a reset in mid-bit leave the switch open and realign every phase.

// File: rtl/lmod_pkg.sv
`timescale 1ns/1ps
package lmod_pkg;

    // Default carrier divisors for the two subcarriers and the two bit rates.
    localparam int SC_HI_DIV_DEF = 32;
    localparam int SC_LO_DIV_DEF = 28;
    localparam int FAST_DIV_DEF  = 512;
    localparam int SLOW_DIV_DEF  = 2048;

    // Transmit state held across a bit period.
    typedef struct packed {
        logic active;  // a bit is being sent
        logic data;    // the bit being sent
        logic fsk;     // mode latched at the bit edge
        logic slow;    // rate latched at the frame edge
    } tx_state_t;

endpackage

// File: rtl/lmod_subcarrier.sv
`timescale 1ns/1ps
// Free-running divide-by-DIV square wave, high during the first DIV/2 counts.
module lmod_subcarrier #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst,
    output logic wave
);
    localparam int            CW   = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (rst) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign wave = (cnt_q < HALF);
endmodule

// File: rtl/lmod_bit_timer.sv
`timescale 1ns/1ps
// Bit counter shared by both rates. FAST_DIV and SLOW_DIV must be powers of
// two with SLOW_DIV a multiple of FAST_DIV, so a slow edge is also a fast edge.
module lmod_bit_timer #(
    parameter int FAST_DIV = 512,
    parameter int SLOW_DIV = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_sel,
    output logic bit_end,
    output logic frame_end,
    output logic second_half
);
    localparam int FAST_W = $clog2(FAST_DIV);
    localparam int SLOW_W = $clog2(SLOW_DIV);

    logic [SLOW_W-1:0] cnt_d, cnt_q;
    logic              fast_end;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (rst) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign fast_end    = &cnt_q[FAST_W-1:0];
    assign frame_end   = &cnt_q;
    assign bit_end     = slow_sel ? frame_end : fast_end;
    assign second_half = slow_sel ? cnt_q[SLOW_W-1] : cnt_q[FAST_W-1];
endmodule

// File: rtl/lmod_modulator.sv
`timescale 1ns/1ps
// Manchester level from data and half-bit phase, then subcarrier selection.
module lmod_modulator (
    input  logic active,
    input  logic data,
    input  logic fsk,
    input  logic second_half,
    input  logic sc_hi,
    input  logic sc_lo,
    output logic sw
);
    logic level;

    always_comb begin
        level = data ^ second_half;  // 1: high then low, 0: low then high
        sw    = 1'b0;
        if (active) begin
            sw = level ? sc_hi : (fsk & sc_lo);
        end
    end
endmodule

// File: rtl/lmod_encoder.sv
`timescale 1ns/1ps
module lmod_encoder
    import lmod_pkg::*;
#(
    parameter int SC_HI_DIV = SC_HI_DIV_DEF,
    parameter int SC_LO_DIV = SC_LO_DIV_DEF,
    parameter int FAST_DIV  = FAST_DIV_DEF,
    parameter int SLOW_DIV  = SLOW_DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic fsk_mode,
    input  logic slow_rate,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic load_sw
);
    localparam int NUM_SC = 2;

    logic [NUM_SC-1:0] sc_wave;   // [0] high subcarrier, [1] low subcarrier
    logic              bit_end;
    logic              frame_end;
    logic              second_half;
    tx_state_t         tx_d, tx_q;

    for (genvar g = 0; g < NUM_SC; g++) begin : g_sc
        lmod_subcarrier #(
            .DIV((g == 0) ? SC_HI_DIV : SC_LO_DIV)
        ) u_sc (
            .clk  (clk),
            .rst  (rst),
            .wave (sc_wave[g])
        );
    end

    lmod_bit_timer #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .slow_sel    (tx_q.slow),
        .bit_end     (bit_end),
        .frame_end   (frame_end),
        .second_half (second_half)
    );

    always_comb begin
        tx_d = tx_q;
        if (bit_end) begin
            tx_d.active = in_valid;
            tx_d.data   = in_valid ? in_bit : tx_q.data;
            tx_d.fsk    = fsk_mode;
        end
        if (frame_end) begin
            tx_d.slow = slow_rate;
        end
        if (rst) begin
            tx_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        tx_q <= tx_d;
    end

    lmod_modulator u_mod (
        .active      (tx_q.active),
        .data        (tx_q.data),
        .fsk         (tx_q.fsk),
        .second_half (second_half),
        .sc_hi       (sc_wave[0]),
        .sc_lo       (sc_wave[1]),
        .sw          (load_sw)
    );

    assign in_ready = bit_end & ~rst;
endmodule

// File: rtl/lmod_encoder_chk.sv
`timescale 1ns/1ps
module lmod_encoder_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_bit,
    input logic in_ready,
    input logic load_sw,
    input logic active,
    input logic data,
    input logic fsk,
    input logic slow,
    input logic second_half,
    input logic frame_end
);
    assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    assert_take_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (active && (data == $past(in_bit))));

    assert_hold_bit_R4: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> ($stable(active) && $stable(data)));

    assert_ask_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (active && !fsk && (data == second_half)) |-> !load_sw);

    assert_idle_open_R8: assert property (@(posedge clk) disable iff (rst)
        !active |-> !load_sw);

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(fsk));

    assert_rate_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(slow));
endmodule

bind lmod_encoder lmod_encoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_bit      (in_bit),
    .in_ready    (in_ready),
    .load_sw     (load_sw),
    .active      (tx_q.active),
    .data        (tx_q.data),
    .fsk         (tx_q.fsk),
    .slow        (tx_q.slow),
    .second_half (second_half),
    .frame_end   (frame_end)
);

// File: tb/lmod_encoder_bench.sv
`timescale 1ns/1ps
module lmod_encoder_bench;
    logic clk       = 1'b0;
    logic rst       = 1'b1;
    logic fsk_mode  = 1'b0;
    logic slow_rate = 1'b0;
    logic in_valid  = 1'b0;
    logic in_bit    = 1'b0;
    logic in_ready;
    logic load_sw;

    always #10 clk = ~clk;  // 50 MHz

    lmod_encoder u_lmod_encoder (
        .clk       (clk),
        .rst       (rst),
        .fsk_mode  (fsk_mode),
        .slow_rate (slow_rate),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .load_sw   (load_sw)
    );

    int checks = 0;
    int failures = 0;
    int t = 0;                 // cycles since reset release
    logic m_act = 0, m_bit = 0, m_fsk = 0, m_slow = 0;
    int sw_err, rdy_err, sw_high, n;
    logic bnd;

    // Vectors {fsk, slow, bit}, sent back to back.
    localparam logic [2:0] VECS [11] = '{
        3'b101, 3'b100, 3'b001, 3'b000, 3'b110, 3'b111,
        3'b011, 3'b010, 3'b101, 3'b000, 3'b100
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t = 0;
        m_act = 0; m_bit = 0; m_fsk = 0; m_slow = 0;
    endtask

    // Called at a negedge: drive inputs, compare against the model, advance.
    task automatic cycle(input logic v, input logic b, input logic f, input logic s,
                         output logic edge_seen);
        logic exp_rdy, half2, lvl, sc, exp_sw;
        in_valid = v; in_bit = b; fsk_mode = f; slow_rate = s;
        #1;
        exp_rdy = m_slow ? ((t % 2048) == 2047) : ((t % 512) == 511);
        half2   = m_slow ? ((t % 2048) >= 1024) : ((t % 512) >= 256);
        lvl     = m_bit ^ half2;
        sc      = lvl ? ((t % 32) < 16) : (m_fsk && ((t % 28) < 14));
        exp_sw  = m_act ? sc : 1'b0;
        if (load_sw !== exp_sw) sw_err++;
        if (in_ready !== exp_rdy) rdy_err++;
        if (load_sw) sw_high++;
        if (exp_rdy) begin
            m_act = v;
            if (v) m_bit = b;
            m_fsk = f;
        end
        if ((t % 2048) == 2047) m_slow = s;
        t++;
        edge_seen = exp_rdy;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        check(load_sw === 1'b0, "R1 load_sw after reset", int'(load_sw), 0);
        check(in_ready === 1'b0, "R1 in_ready after reset", int'(in_ready), 0);

        foreach (VECS[i]) begin
            sw_err = 0; rdy_err = 0;
            do cycle(1'b1, VECS[i][0], VECS[i][2], VECS[i][1], bnd); while (!bnd);
            check(sw_err == 0, VECS[i][2] ? "R2 R5 R6 R9 output waveform"
                                          : "R2 R5 R7 R9 output waveform", sw_err, 0);
            check(rdy_err == 0, "R3 R4 R10 bit edge timing", rdy_err, 0);
        end

        // Idle: last bit plays out, then a full period with nothing taken.
        sw_err = 0; rdy_err = 0;
        do cycle(1'b0, 1'b0, 1'b1, 1'b0, bnd); while (!bnd);
        sw_high = 0;
        do cycle(1'b0, 1'b1, 1'b1, 1'b0, bnd); while (!bnd);
        check(sw_high == 0, "R8 idle switch activity", sw_high, 0);
        check(sw_err + rdy_err == 0, "R3 R8 idle model mismatches", sw_err + rdy_err, 0);

        // Reset in the middle of a slow FSK bit realigns all phases.
        do cycle(1'b1, 1'b1, 1'b1, 1'b1, bnd); while (!bnd);
        repeat (300) cycle(1'b0, 1'b0, 1'b1, 1'b1, bnd);
        do_reset();
        check(load_sw === 1'b0, "R1 load_sw after mid-bit reset", int'(load_sw), 0);
        check(in_ready === 1'b0, "R1 in_ready after mid-bit reset", int'(in_ready), 0);
        sw_err = 0; rdy_err = 0; n = 0;
        do begin
            cycle(1'b0, 1'b0, 1'b0, 1'b0, bnd);
            n++;
        end while (!bnd);
        check(n == 512, "R1 R3 first edge after reset", n, 512);
        check(sw_err + rdy_err == 0, "R1 post-reset mismatches", sw_err + rdy_err, 0);

        // ASK bit right after reset: fast rate, first edge at count 511.
        sw_err = 0; rdy_err = 0;
        do cycle(1'b1, 1'b0, 1'b0, 1'b0, bnd); while (!bnd);
        do cycle(1'b0, 1'b0, 1'b0, 1'b0, bnd); while (!bnd);
        check(sw_err + rdy_err == 0, "R5 R7 ASK zero bit after reset", sw_err + rdy_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule